// File: doc/BRIEF.md
# Three-Phase Deadtime Injector

This block converts three single-ended PWM phase commands into three non-overlapping pairs of switch drive lines, one high-side and one low-side line per phase. Whenever a phase command changes level, the line that is conducting is released first. The opposite line is switched on only after a fixed number of clock cycles in which both lines of the pair are low. Every phase uses the same gap length and runs its own counter, so the three phases act fully in parallel.

Each command is brought into the clock domain through a two-stage synchronizer. A change of the synchronized level during a gap restarts that gap, so a pulse shorter than the gap never turns on a drive line; it only makes the gap longer. The counter state is gated in front of the outputs, combinationally and without a clock, by three per-phase enables, a global enable and the reset. Reset is synchronous and active high. After reset is released, every phase starts a full gap towards its current command.

Top module: `dt_inject3`

## Requirements
- R1: While a phase is not in a gap, its high-side line equals the synchronized command and its low-side line is the complement (command 1 gives hi=1 lo=0, command 0 gives hi=0 lo=1).
- R2: A command change is synchronized by two flops; the conducting line of that phase goes low on the third rising clock edge after the change is applied between edges.
- R3: After the conducting line goes low, both lines of the phase stay low for exactly DEADTIME clock cycles (default 8) before the opposite line goes high; the two lines of a phase are never high together.
- R4: All phases use the same DEADTIME and run independently; changes applied to several phases in the same cycle complete in the same cycles.
- R5: A low per-phase enable forces both lines of that phase low at once, without waiting for a clock edge; the other phases are unaffected.
- R6: A low global enable forces all six lines low at once, without waiting for a clock edge.
- R7: While reset is high all six lines are low, without waiting for a clock edge; after reset falls, a phase with command 0 turns its low-side line on after DEADTIME rising edges, and a phase with command 1 turns its high-side line on after DEADTIME+3 rising edges.
- R8: Enables do not stop the counters; when an enable returns high, the present internal state of the phase appears at its lines at once, with no extra gap inserted.
- R9: A command pulse shorter than DEADTIME never turns on the opposite line; the gap is restarted at the pulse's end and lasts the pulse length plus DEADTIME cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all timing is counted on its rising edge |
| rst | input | 1 | Synchronous active-high reset; also forces the lines low at once |
| ph_cmd | input | NUM_PH | PWM command per phase (1 = high side on) |
| ph_en | input | NUM_PH | Per-phase enable, active high |
| all_en | input | 1 | Global enable, active high |
| drv_hi | output | NUM_PH | High-side drive line per phase |
| drv_lo | output | NUM_PH | Low-side drive line per phase |

## Verification
A counter or target level held in the wrong state shows up at the drive lines within one gap. Depending on the fault, a pair goes high together, a gap comes out one cycle short or long, or a glitch reaches the opposite line. Faults in the synchronizer shift the turn-off edge away from the third rising edge, and the bench samples that edge on its own. Errors in the enable gating appear within the same cycle, because the bench samples the lines one time step after it drives an enable or the reset, before any clock edge.

// File: rtl/dt_pkg.sv
package dt_pkg;

    typedef enum logic {
        MODE_DEAD  = 1'b0,
        MODE_DRIVE = 1'b1
    } dt_mode_e;

    typedef struct packed {
        logic hi;
        logic lo;
    } dt_pair_t;

    localparam dt_pair_t PAIR_OFF = '{hi: 1'b0, lo: 1'b0};

    function automatic dt_pair_t pair_from(dt_mode_e m, logic lvl);
        dt_pair_t p;
        p.hi = (m == MODE_DRIVE) && lvl;
        p.lo = (m == MODE_DRIVE) && !lvl;
        return p;
    endfunction

    function automatic int unsigned cnt_width(int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dt_sync.sv
module dt_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < int'(STAGES); i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < int'(STAGES); i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/dt_phase_core.sv
module dt_phase_core
    import dt_pkg::*;
#(
    parameter int unsigned DEADTIME = 8
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cmd_s,
    output dt_pair_t pair_o
);
    localparam int unsigned CW = cnt_width(DEADTIME);
    localparam logic [CW-1:0] CNT_LAST = CW'(DEADTIME - 1);

    dt_mode_e        mode_q;
    logic            tgt_q;
    logic [CW-1:0]   cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_DEAD;
            tgt_q  <= 1'b0;
            cnt_q  <= '0;
        end else if (cmd_s != tgt_q) begin
            // new level or glitch: release outputs, restart the gap
            tgt_q  <= cmd_s;
            mode_q <= MODE_DEAD;
            cnt_q  <= '0;
        end else if (mode_q == MODE_DEAD) begin
            if (cnt_q == CNT_LAST) begin
                mode_q <= MODE_DRIVE;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign pair_o = pair_from(mode_q, tgt_q);

    // checker: length of the current all-off stretch, saturating
    logic [CW:0] gap_q;
    always_ff @(posedge clk) begin
        if (rst)                        gap_q <= '0;
        else if (pair_o.hi || pair_o.lo) gap_q <= '0;
        else if (gap_q != (CW+1)'(DEADTIME)) gap_q <= gap_q + 1'b1;
    end

    AST_HOLD_DRIVE: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_DRIVE && cmd_s == tgt_q) |=> $stable(pair_o)); // R1

    AST_OFF_ON_CHANGE: assert property (@(posedge clk) disable iff (rst)
        ((pair_o.hi || pair_o.lo) && cmd_s != tgt_q) |=> (pair_o == PAIR_OFF)); // R2

    AST_GAP_EXACT: assert property (@(posedge clk) disable iff (rst)
        ((pair_o.hi || pair_o.lo) && !$past(pair_o.hi || pair_o.lo))
        |-> (gap_q == (CW+1)'(DEADTIME))); // R3

    AST_GLITCH_HELD: assert property (@(posedge clk) disable iff (rst)
        (mode_q == MODE_DEAD && cmd_s != tgt_q) |=> (pair_o == PAIR_OFF)); // R9

    AST_RESET_DEAD: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pair_o == PAIR_OFF)); // R7
endmodule

// File: rtl/dt_gate.sv
module dt_gate
    import dt_pkg::*;
#(
    parameter int unsigned NUM_PH = 3
) (
    input  logic                  rst,
    input  dt_pair_t [NUM_PH-1:0] pairs,
    input  logic [NUM_PH-1:0]     ph_en,
    input  logic                  all_en,
    output logic [NUM_PH-1:0]     drv_hi,
    output logic [NUM_PH-1:0]     drv_lo
);
    for (genvar i = 0; i < int'(NUM_PH); i++) begin : g_ph
        logic pass;
        assign pass      = ph_en[i] && all_en && !rst;
        assign drv_hi[i] = pairs[i].hi && pass;
        assign drv_lo[i] = pairs[i].lo && pass;

        always_comb begin
            AST_PAIR_EXCLUSIVE: assert (!(drv_hi[i] && drv_lo[i])); // R3
        end
    end
endmodule

// File: rtl/dt_inject3.sv
module dt_inject3
    import dt_pkg::*;
#(
    parameter int unsigned NUM_PH      = 3,
    parameter int unsigned DEADTIME    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_PH-1:0] ph_cmd,
    input  logic [NUM_PH-1:0] ph_en,
    input  logic              all_en,
    output logic [NUM_PH-1:0] drv_hi,
    output logic [NUM_PH-1:0] drv_lo
);
    logic [NUM_PH-1:0]     cmd_s;
    dt_pair_t [NUM_PH-1:0] pairs;

    dt_sync #(.WIDTH(NUM_PH), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (ph_cmd),
        .q   (cmd_s)
    );

    for (genvar i = 0; i < int'(NUM_PH); i++) begin : g_core
        dt_phase_core #(.DEADTIME(DEADTIME)) u_core (
            .clk    (clk),
            .rst    (rst),
            .cmd_s  (cmd_s[i]),
            .pair_o (pairs[i])
        );
    end

    dt_gate #(.NUM_PH(NUM_PH)) u_gate (
        .rst    (rst),
        .pairs  (pairs),
        .ph_en  (ph_en),
        .all_en (all_en),
        .drv_hi (drv_hi),
        .drv_lo (drv_lo)
    );
endmodule

// File: tb/test_dt_inject3.sv
module test_dt_inject3;
    localparam int DT = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] cmd = 3'b000;
    logic [2:0] en  = 3'b111;
    logic       gen = 1'b1;
    logic [2:0] hi, lo;
    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dt_inject3 #(.NUM_PH(3), .DEADTIME(DT), .SYNC_STAGES(2)) i_dt_inject3 (
        .clk(clk), .rst(rst), .ph_cmd(cmd), .ph_en(en), .all_en(gen),
        .drv_hi(hi), .drv_lo(lo)
    );

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, int ph, logic eh, logic el);
        checks++;
        if (hi[ph] !== eh || lo[ph] !== el) begin
            errs++;
            $display("FAIL %s phase %0d: hi/lo=%b%b expected %b%b", tag, ph, hi[ph], lo[ph], eh, el);
        end
    endtask

    // R3: the two lines of a phase are never high together
    always @(negedge clk) begin
        if (!done) begin
            for (int p = 0; p < 3; p++) begin
                checks++;
                if (hi[p] === 1'b1 && lo[p] === 1'b1) begin
                    errs++;
                    $display("FAIL R3 overlap phase %0d: hi/lo=11 expected not 11", p);
                end
            end
        end
    end

    task automatic t_reset();
        rst = 1'b1; cmd = 3'b000; en = 3'b111; gen = 1'b1;
        step(3);
        for (int p = 0; p < 3; p++) chk("R7 in reset", p, 0, 0);
        rst = 1'b0;
        step(DT-1);
        for (int p = 0; p < 3; p++) chk("R7 gap after release", p, 0, 0);
        step(1);
        for (int p = 0; p < 3; p++) chk("R1 low side after reset gap", p, 0, 1);
    endtask

    task automatic t_switch(int ph, logic lvl);
        cmd[ph] = lvl;
        step(2);
        chk("R2 still old level", ph, !lvl, lvl);
        step(1);
        chk("R2 off at third edge", ph, 0, 0);
        step(DT-1);
        chk("R3 gap last cycle", ph, 0, 0);
        step(1);
        chk("R1 new level after gap", ph, lvl, !lvl);
    endtask

    task automatic t_simul();
        // phase0 is 1 -> 0, phase1 is 0 -> 1, phase2 holds 0
        cmd[0] = 1'b0; cmd[1] = 1'b1;
        step(3);
        chk("R4 ph0 gap", 0, 0, 0);
        chk("R4 ph1 gap", 1, 0, 0);
        chk("R4 ph2 untouched", 2, 0, 1);
        step(DT);
        chk("R4 ph0 done", 0, 0, 1);
        chk("R4 ph1 done", 1, 1, 0);
        chk("R4 ph2 untouched", 2, 0, 1);
    endtask

    task automatic t_glitch(int ph, int k);
        logic lv;
        lv = cmd[ph];
        cmd[ph] = !lv;
        for (int t = 1; t <= 3 + k + DT; t++) begin
            step(1);
            if (t == k) cmd[ph] = lv;
            if (t < 3 || t == 3 + k + DT) chk("R9 glitch level", ph, lv, !lv);
            else chk("R9 glitch held off", ph, 0, 0);
        end
    endtask

    task automatic t_phase_en();
        // state: ph0 01, ph1 10, ph2 01
        en[1] = 1'b0; #1;
        chk("R5 disabled phase", 1, 0, 0);
        chk("R5 other phase", 0, 0, 1);
        chk("R5 other phase", 2, 0, 1);
        en[1] = 1'b1; #1;
        chk("R8 immediate restore", 1, 1, 0);
        step(1);
        en[0] = 1'b0; cmd[0] = 1'b1;
        step(5);
        chk("R5 disabled during switch", 0, 0, 0);
        en[0] = 1'b1; #1;
        chk("R8 restore inside gap", 0, 0, 0);
        step(DT-3);
        chk("R8 gap not extended", 0, 0, 0);
        step(1);
        chk("R8 on at original time", 0, 1, 0);
    endtask

    task automatic t_global();
        // state: ph0 10, ph1 10, ph2 01
        gen = 1'b0; #1;
        for (int p = 0; p < 3; p++) chk("R6 global off", p, 0, 0);
        step(2);
        for (int p = 0; p < 3; p++) chk("R6 global off held", p, 0, 0);
        gen = 1'b1; #1;
        chk("R8 global restore", 0, 1, 0);
        chk("R8 global restore", 1, 1, 0);
        chk("R8 global restore", 2, 0, 1);
    endtask

    task automatic t_reset_mid();
        rst = 1'b1; #1;
        for (int p = 0; p < 3; p++) chk("R7 immediate off", p, 0, 0);
        step(2);
        rst = 1'b0; cmd = 3'b001;
        step(DT-1);
        for (int p = 0; p < 3; p++) chk("R7 full gap", p, 0, 0);
        step(1);
        chk("R7 cmd0 after gap", 1, 0, 1);
        chk("R7 cmd0 after gap", 2, 0, 1);
        chk("R7 cmd1 still off", 0, 0, 0);
        step(2);
        chk("R7 cmd1 still off", 0, 0, 0);
        step(1);
        chk("R7 cmd1 after sync and gap", 0, 1, 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: run did not complete, expected completion");
        report();
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_switch(0, 1'b1);   // R1 R2 R3
        t_switch(0, 1'b0);
        t_switch(0, 1'b1);
        t_simul();
        t_glitch(2, 1);
        t_glitch(1, DT-1);
        t_phase_en();
        t_global();
        t_reset_mid();
        step(2);
        report();
    end
endmodule